// File: doc/BRIEF.md
# Byte-Serial Operand Port for a Fixed-to-Posit Adder

This block sits between an 8-bit host data path and a datapath that turns two 16-bit signed fixed-point operands into posit(16,1) values and adds them. The host writes the operands as four bytes. For each operand the low byte goes first, and operand A goes before operand B. The block reacts to each rising edge of a write strobe. After the fourth byte it presents both operands together on its operand outputs and raises a one-cycle start pulse. On the next clock edge it takes a snapshot of the results that the attached converter and adder drive back to it.

Readback is paced by a second strobe. Each rising edge of that strobe moves one byte of a fixed twelve-entry sequence onto the read output, and the byte stays there until the next rising edge. The sequence holds the raw operands, the packed sign/regime/exponent fields of both converted operands, their mantissas and the posit sum. The strobe level is ignored after its rising edge, so the host may hold a strobe high for any number of cycles. Both byte counters return to zero after their last entry.

Top module: `posit_byte_port`

## Requirements
- R1: While `rst` is high at a clock edge, the following are cleared at that edge: the write and read positions, `op_a`, `op_b`, `rd_data`, `calc_start` and the result snapshot. After `rst` falls, the first byte written is taken as the low byte of A, and the first byte read is slot 0.
- R2: Each write byte is taken exactly once, at the first clock edge where `wr_vld` is sampled high after being sampled low. The same data results whether the strobe is held for 2 cycles or for many.
- R3: The write order is A[7:0], A[15:8], B[7:0], B[15:8]. `op_a` and `op_b` keep their values until the clock edge that takes the fourth byte, and both update at that edge.
- R4: `calc_start` is high for exactly the one cycle that follows the edge taking the fourth byte, and is low at all other times.
- R5: At the edge where `calc_start` is high, `a_hdr`, `b_hdr`, `a_mant`, `b_mant` and `sum_p` are captured. Later changes on those inputs have no effect on readback until the next complete write.
- R6: Read slots 0 to 11 return, in this order: A low, A high, B low, B high, `a_hdr`, `b_hdr`, `a_mant` high, `a_mant` low, `b_mant` high, `b_mant` low, `sum_p` low, `sum_p` high.
- R7: `rd_data` changes only at the clock edge that detects a rising `rd_vld`. It shows the selected slot from the cycle after that edge until the next rise.
- R8: After four writes the write position returns to 0, so a fifth byte starts a new A low byte. After slot 11 the read position returns to 0.
- R9: A reset in the middle of a write sequence discards the bytes already taken. The next four bytes form a complete, correct operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_vld | input | 1 | Write strobe; a rising edge takes one byte |
| wr_data | input | 8 | Write byte |
| rd_vld | input | 1 | Read strobe; a rising edge moves to the next slot |
| rd_data | output | 8 | Byte of the current read slot |
| op_a | output | 16 | Fixed-point operand A, to the converter |
| op_b | output | 16 | Fixed-point operand B, to the converter |
| calc_start | output | 1 | One-cycle pulse when fresh operands are present |
| a_hdr | input | 8 | Packed sign/regime/exponent of converted A |
| b_hdr | input | 8 | Packed sign/regime/exponent of converted B |
| a_mant | input | 16 | Mantissa of converted A |
| b_mant | input | 16 | Mantissa of converted B |
| sum_p | input | 16 | Posit sum |

## Verification
The operand outputs and `calc_start` are due one cycle after the strobe edge that takes the fourth byte. The bench samples them at the falling edge that follows that clock edge, then samples one falling edge later to confirm that the pulse is gone. The result snapshot is taken one further cycle later. The bench changes the stub arithmetic outputs only after the write sequence has finished, so the readback shows whether the snapshot was taken at the correct cycle. `rd_data` is due one cycle after a read rise. It is sampled at the first falling edge after the rise, again before the strobe drops, and again at the end of the idle gap, to confirm that it does not move between rises.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 16;
    localparam int LANES    = WORD_W / BYTE_W;
    localparam int WR_BYTES = 2 * LANES;
    localparam int RD_SLOTS = 12;
    localparam int WR_IDX_W = $clog2(WR_BYTES);
    localparam int RD_IDX_W = $clog2(RD_SLOTS);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    // readback ordering: the host depends on this sequence
    typedef enum logic [RD_IDX_W-1:0] {
        SL_A_LO, SL_A_HI, SL_B_LO, SL_B_HI,
        SL_A_HDR, SL_B_HDR,
        SL_A_MHI, SL_A_MLO, SL_B_MHI, SL_B_MLO,
        SL_S_LO, SL_S_HI
    } slot_e;

    typedef struct packed {
        byte_t a_hdr;
        byte_t b_hdr;
        word_t a_mant;
        word_t b_mant;
        word_t sum;
    } res_t;

    function automatic byte_t lo_of(word_t w);
        return w[BYTE_W-1:0];
    endfunction

    function automatic byte_t hi_of(word_t w);
        return w[WORD_W-1 -: BYTE_W];
    endfunction
endpackage

// File: rtl/pbp_edge.sv
module pbp_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/pbp_wr_collect.sv
module pbp_wr_collect
    import pbp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rise,
    input  byte_t din,
    output word_t op_a,
    output word_t op_b,
    output logic  start
);
    localparam int FULL_W = WR_BYTES * BYTE_W;

    logic [WR_IDX_W-1:0] idx;
    byte_t               stage [WR_BYTES-1];
    logic [FULL_W-1:0]   full;
    logic                last;

    assign last = (idx == WR_IDX_W'(WR_BYTES - 1));

    genvar g;
    generate
        for (g = 0; g < WR_BYTES - 1; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage[g] <= '0;
                else if (rise && idx == WR_IDX_W'(g))
                    stage[g] <= din;
            end
        end
    endgenerate

    always_comb begin
        full = '0;
        for (int i = 0; i < WR_BYTES - 1; i++)
            full[i*BYTE_W +: BYTE_W] = stage[i];
        full[(WR_BYTES-1)*BYTE_W +: BYTE_W] = din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            op_a  <= '0;
            op_b  <= '0;
            start <= 1'b0;
        end else begin
            start <= 1'b0;
            if (rise) begin
                if (last) begin
                    idx   <= '0;
                    op_a  <= full[WORD_W-1:0];
                    op_b  <= full[2*WORD_W-1:WORD_W];
                    start <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R2
    wr_idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(idx));
    // R3
    op_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rise && last) |=> ($stable(op_a) && $stable(op_b)));
    // R4
    start_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && last) |=> start);
    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);
    // R8
    wr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && last) |=> idx == '0);
endmodule

// File: rtl/pbp_rd_seq.sv
module pbp_rd_seq
    import pbp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rise,
    input  logic  start,
    input  word_t op_a,
    input  word_t op_b,
    input  res_t  res_in,
    output byte_t rd_byte
);
    res_t                held;
    byte_t               slots [RD_SLOTS];
    logic [RD_IDX_W-1:0] idx;
    logic                last;

    assign last = (idx == RD_IDX_W'(RD_SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst)        held <= '0;
        else if (start) held <= res_in;
    end

    always_comb begin
        slots[SL_A_LO]  = lo_of(op_a);
        slots[SL_A_HI]  = hi_of(op_a);
        slots[SL_B_LO]  = lo_of(op_b);
        slots[SL_B_HI]  = hi_of(op_b);
        slots[SL_A_HDR] = held.a_hdr;
        slots[SL_B_HDR] = held.b_hdr;
        slots[SL_A_MHI] = hi_of(held.a_mant);
        slots[SL_A_MLO] = lo_of(held.a_mant);
        slots[SL_B_MHI] = hi_of(held.b_mant);
        slots[SL_B_MLO] = lo_of(held.b_mant);
        slots[SL_S_LO]  = lo_of(held.sum);
        slots[SL_S_HI]  = hi_of(held.sum);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx     <= '0;
            rd_byte <= '0;
        end else if (rise) begin
            rd_byte <= slots[idx];
            idx     <= last ? '0 : idx + 1'b1;
        end
    end

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(rd_byte));
    // R8
    rd_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && last) |=> idx == '0);
    // R8
    rd_range_chk: assert property (@(posedge clk) disable iff (rst)
        idx < RD_IDX_W'(RD_SLOTS));
    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(held));
endmodule

// File: rtl/posit_byte_port.sv
module posit_byte_port (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_vld,
    input  logic [pbp_pkg::BYTE_W-1:0] wr_data,
    input  logic                       rd_vld,
    output logic [pbp_pkg::BYTE_W-1:0] rd_data,
    output logic [pbp_pkg::WORD_W-1:0] op_a,
    output logic [pbp_pkg::WORD_W-1:0] op_b,
    output logic                       calc_start,
    input  logic [pbp_pkg::BYTE_W-1:0] a_hdr,
    input  logic [pbp_pkg::BYTE_W-1:0] b_hdr,
    input  logic [pbp_pkg::WORD_W-1:0] a_mant,
    input  logic [pbp_pkg::WORD_W-1:0] b_mant,
    input  logic [pbp_pkg::WORD_W-1:0] sum_p
);
    import pbp_pkg::*;

    logic wr_rise, rd_rise;
    res_t res_in;

    assign res_in = '{a_hdr: a_hdr, b_hdr: b_hdr, a_mant: a_mant,
                      b_mant: b_mant, sum: sum_p};

    pbp_edge u_wr_edge (.clk(clk), .rst(rst), .lvl(wr_vld), .rise(wr_rise));
    pbp_edge u_rd_edge (.clk(clk), .rst(rst), .lvl(rd_vld), .rise(rd_rise));

    pbp_wr_collect u_wr (
        .clk(clk), .rst(rst), .rise(wr_rise), .din(wr_data),
        .op_a(op_a), .op_b(op_b), .start(calc_start)
    );

    pbp_rd_seq u_rd (
        .clk(clk), .rst(rst), .rise(rd_rise), .start(calc_start),
        .op_a(op_a), .op_b(op_b), .res_in(res_in), .rd_byte(rd_data)
    );

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (op_a == '0 && op_b == '0 && rd_data == '0 && !calc_start));
endmodule

// File: tb/posit_byte_port_bench.sv
module posit_byte_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_vld = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_vld = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] op_a, op_b;
    logic        calc_start;
    logic [7:0]  a_hdr, b_hdr;
    logic [15:0] a_mant, b_mant, sum_p;
    logic        scr = 1'b0;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    // stub arithmetic driven from the operand outputs
    function automatic logic [7:0] f_hdr(logic [15:0] w);
        return w[15:8] ^ w[7:0] ^ 8'h3C;
    endfunction
    function automatic logic [15:0] f_mant(logic [15:0] w);
        return {w[7:0], w[15:8]} + 16'h1357;
    endfunction
    function automatic logic [15:0] f_sum(logic [15:0] a, logic [15:0] b);
        return (a + b) ^ 16'h0F0F;
    endfunction

    assign a_hdr  = f_hdr(op_a)  ^ {8{scr}};
    assign b_hdr  = f_hdr(op_b)  ^ {8{scr}};
    assign a_mant = f_mant(op_a) ^ {16{scr}};
    assign b_mant = f_mant(op_b) ^ {16{scr}};
    assign sum_p  = f_sum(op_a, op_b) ^ {16{scr}};

    posit_byte_port u_posit_byte_port (
        .clk(clk), .rst(rst), .wr_vld(wr_vld), .wr_data(wr_data),
        .rd_vld(rd_vld), .rd_data(rd_data), .op_a(op_a), .op_b(op_b),
        .calc_start(calc_start), .a_hdr(a_hdr), .b_hdr(b_hdr),
        .a_mant(a_mant), .b_mant(b_mant), .sum_p(sum_p)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_slot(logic [15:0] a, logic [15:0] b, int k);
        logic [15:0] am, bm, s;
        am = f_mant(a); bm = f_mant(b); s = f_sum(a, b);
        case (k)
            0: return a[7:0];   1: return a[15:8];
            2: return b[7:0];   3: return b[15:8];
            4: return f_hdr(a); 5: return f_hdr(b);
            6: return am[15:8]; 7: return am[7:0];
            8: return bm[15:8]; 9: return bm[7:0];
            10: return s[7:0];  default: return s[15:8];
        endcase
    endfunction

    task automatic put_byte(input logic [7:0] b, input int hold);
        @(negedge clk); wr_vld = 1'b1; wr_data = b;
        repeat (hold) @(negedge clk);
        wr_vld = 1'b0; wr_data = ~b;
        repeat (4) @(negedge clk);
    endtask

    // writes a full pair; checks R2, R3, R4 timing on the fourth byte
    task automatic write_pair(input logic [15:0] a, input logic [15:0] b,
                              input int hold, input string tag);
        logic [15:0] pa, pb;
        pa = op_a; pb = op_b;
        put_byte(a[7:0], hold);
        put_byte(a[15:8], hold);
        put_byte(b[7:0], hold);
        chk(op_a == pa && op_b == pb, {"R3 ops held before 4th byte ", tag}, op_a, pa);
        @(negedge clk); wr_vld = 1'b1; wr_data = b[15:8];
        @(negedge clk);
        chk(calc_start == 1'b1, {"R4 start pulse ", tag}, {15'd0, calc_start}, 16'd1);
        chk(op_a == a, {"R3 op_a ", tag}, op_a, a);
        chk(op_b == b, {"R2 R3 op_b ", tag}, op_b, b);
        @(negedge clk);
        chk(calc_start == 1'b0, {"R4 start single cycle ", tag}, {15'd0, calc_start}, 16'd0);
        repeat (hold - 2) @(negedge clk);
        wr_vld = 1'b0;
        repeat (4) @(negedge clk);
        chk(calc_start == 1'b0 && op_a == a, {"R2 no refire on hold ", tag}, op_a, a);
    endtask

    task automatic get_byte(input logic [7:0] exp, input string tag);
        logic [7:0] v1, v2, v3;
        @(negedge clk); rd_vld = 1'b1;
        @(negedge clk); v1 = rd_data;
        repeat (3) @(negedge clk); v2 = rd_data;
        rd_vld = 1'b0;
        repeat (8) @(negedge clk); v3 = rd_data;
        chk(v1 == exp, {"R6 slot ", tag}, {8'd0, v1}, {8'd0, exp});
        chk(v2 == v1 && v3 == v1, {"R7 held ", tag}, {8'd0, v3}, {8'd0, v1});
    endtask

    task automatic t_reset_state;
        chk(op_a == 16'd0 && op_b == 16'd0, "R1 ops cleared", op_a, 16'd0);
        chk(rd_data == 8'd0, "R1 rd_data cleared", {8'd0, rd_data}, 16'd0);
        chk(calc_start == 1'b0, "R1 start low", {15'd0, calc_start}, 16'd0);
    endtask

    task automatic t_read_all(input logic [15:0] a, input logic [15:0] b);
        scr = 1'b1; // R5: arithmetic outputs change after snapshot
        for (int k = 0; k < 12; k++)
            get_byte(exp_slot(a, b, k), $sformatf("R5 k=%0d", k));
        get_byte(exp_slot(a, b, 0), "R8 read wrap");
        for (int k = 1; k < 12; k++) get_byte(exp_slot(a, b, k), $sformatf("R8 k=%0d", k));
        scr = 1'b0;
    endtask

    task automatic t_reset_mid;
        put_byte(8'hDE, 4);
        put_byte(8'hAD, 4);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        chk(op_a == 16'd0, "R9 reset clears ops", op_a, 16'd0);
        write_pair(16'h8001, 16'h7FFE, 4, "R9 after reset");
        get_byte(exp_slot(16'h8001, 16'h7FFE, 0), "R9 R1 read from slot 0");
        get_byte(exp_slot(16'h8001, 16'h7FFE, 1), "R9 slot1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        write_pair(16'h1234, 16'hF00D, 4, "R2 hold4");
        t_read_all(16'h1234, 16'hF00D);
        write_pair(16'hA55A, 16'h0001, 11, "R2 R8 long hold, write wrap");
        t_read_all(16'hA55A, 16'h0001);
        t_reset_mid();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule